// File: doc/BRIEF.md
# DMA Channel Control and Status Register Bank

This block is the software-visible register file of a 64-channel DMA engine. It sits on a plain 32-bit memory-mapped write bus with byte enables and a combinational read port. It holds a 64-bit request-enable bitmap, a 64-bit error-interrupt-enable bitmap, 64 interrupt-request flags, 64 error flags, a global control word and a captured error-status word.

Every 64-bit bitmap is seen as two 32-bit words. The high word carries channels 63..32 on bits 31..0, and the low word carries channels 31..0. Apart from whole-word access, software can change a single channel's bit without a read-modify-write. It does this by writing the channel number into a byte lane of one of two command words. Each lane of those words is a separate set or clear port.

The channel engines report to the block through a small number of event sources. Each source can pulse a completion event or an error event in a cycle, tagged with a channel number and a 16-bit cause vector. The block drives one combined interrupt line, the enable bitmaps, the control bits and one-cycle per-channel start and done-clear strobes.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset every register word reads zero, `irq` is low and no bit of `start_pulse` or `done_clr` is set.
- R2: The control word (word 0) keeps only bits 31, 3 and 2, and every other bit reads zero. These bits drive `clk_gate_en`, `rr_group` and `rr_chan`. A lane whose byte enable is low keeps its old value.
- R3: Words 2/3 (request enable, high/low) and 4/5 (error-interrupt enable, high/low) are read/write with per-byte enables. High-word bit i is channel 32+i, and low-word bit i is channel i.
- R4: In command word 6, byte lane 0 sets and lane 1 clears a channel's request enable, and lane 2 sets and lane 3 clears its error-interrupt enable. The channel number is lane bits 5:0, and lane bits 7:6 are ignored. A lane acts only when its byte enable is set.
- R5: In command word 7, a write to lane 2 gives a one-cycle pulse on `start_pulse[ch]`, and a write to lane 3 gives a one-cycle pulse on `done_clr[ch]`. Each pulse appears in the clock cycle after the write edge.
- R6: A completion event sets the channel's interrupt flag whatever the enables are. The flags read at words 8 (high) and 9 (low), which are write-one-to-clear, so writing all ones clears the word.
- R7: An error event sets the channel's error flag at words 10 (high) and 11 (low), which are write-one-to-clear. That flag reaches `irq` only while the channel's error-interrupt enable is set.
- R8: In command word 7, lane 0 clears one channel's interrupt flag and lane 1 clears one channel's error flag. No other channel's flag changes.
- R9: When an event sets a flag in the same cycle that a bus write clears it, the flag ends up set.
- R10: While status word 1 is not valid, an error event loads it: bit 31 set, the channel in bits 13:8, and the cause bits 15, 14 and 7:0 copied from the event (other bits zero). Later errors leave it unchanged. A write to word 1 with lane 3 enabled and data bit 31 set clears it.
- R11: When several sources report errors in one cycle, the status word records the lowest channel number and that source's cause.
- R12: `irq` is high exactly when some interrupt flag is set, or some error flag is set whose error-interrupt enable is set. It reflects a new event one cycle after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 6 | Word index of the register |
| bus_be | input | 4 | Byte enables, bit n for data bits 8n+7..8n |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of word `bus_addr` (combinational) |
| evt_done | input | NSRC | Per-source completion event pulse |
| evt_err | input | NSRC | Per-source error event pulse |
| evt_chan | input | 6*NSRC | Per-source channel number, source 0 in the low bits |
| evt_cause | input | 16*NSRC | Per-source error cause vector |
| irq | output | 1 | Combined interrupt |
| req_en | output | 64 | Request-enable bitmap |
| err_int_en | output | 64 | Error-interrupt-enable bitmap |
| start_pulse | output | 64 | One-cycle start strobe per channel |
| done_clr | output | 64 | One-cycle done-clear strobe per channel |
| clk_gate_en | output | 1 | Control bit 31 |
| rr_group | output | 1 | Control bit 3 |
| rr_chan | output | 1 | Control bit 2 |

## Verification
The bench drives an event into a flag in the same cycle that a write-one-to-clear or a command clears it. A design that let software win would silently drop a completion.

It writes command bytes with the top lane bits set and with some byte enables off. A decoder that used all eight bits would select a channel outside the 64. A decoder that ignored the enables would touch the wrong channel.

It raises errors on two sources in one cycle, with the higher channel on source 0, and then sends a further error while status is valid. A priority or hold fault would record the wrong channel or overwrite the first error. It also holds an error with its interrupt enable off and expects `irq` to stay low.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int NCH    = 64;
  localparam int CHW    = $clog2(NCH);
  localparam int DW     = 32;
  localparam int NLANE  = DW / 8;
  localparam int CAUSEW = 16;
  localparam int AW     = 6;

  localparam logic [AW-1:0] A_CTRL    = 6'd0;
  localparam logic [AW-1:0] A_ESTAT   = 6'd1;
  localparam logic [AW-1:0] A_REQEN_H = 6'd2;
  localparam logic [AW-1:0] A_REQEN_L = 6'd3;
  localparam logic [AW-1:0] A_EIEN_H  = 6'd4;
  localparam logic [AW-1:0] A_EIEN_L  = 6'd5;
  localparam logic [AW-1:0] A_CMD_EN  = 6'd6;
  localparam logic [AW-1:0] A_CMD_EV  = 6'd7;
  localparam logic [AW-1:0] A_INT_H   = 6'd8;
  localparam logic [AW-1:0] A_INT_L   = 6'd9;
  localparam logic [AW-1:0] A_ERR_H   = 6'd10;
  localparam logic [AW-1:0] A_ERR_L   = 6'd11;

  localparam logic [DW-1:0]     CTRL_MASK  = 32'h8000_000C;
  localparam logic [CAUSEW-1:0] CAUSE_MASK = 16'hC0FF;

  function automatic logic [NCH-1:0] chan_bit(input logic [CHW-1:0] ch);
    return {{(NCH-1){1'b0}}, 1'b1} << ch;
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [NLANE-1:0] be);
    logic [DW-1:0] m;
    for (int l = 0; l < NLANE; l++) m[8*l +: 8] = {8{be[l]}};
    return m;
  endfunction

  function automatic logic [DW-1:0] rw_merge(input logic [DW-1:0] old_v,
                                             input logic [DW-1:0] new_v,
                                             input logic [DW-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  function automatic logic [DW-1:0] w1c_merge(input logic [DW-1:0] old_v,
                                              input logic [DW-1:0] new_v,
                                              input logic [DW-1:0] m);
    return old_v & ~(new_v & m);
  endfunction

  function automatic logic [DW-1:0] estat_pack(input logic [CHW-1:0] ch,
                                               input logic [CAUSEW-1:0] cause);
    logic [DW-1:0] w;
    w = '0;
    w[31] = 1'b1;
    w[8 +: CHW] = ch;
    w[CAUSEW-1:0] = w[CAUSEW-1:0] | (cause & CAUSE_MASK);
    return w;
  endfunction
endpackage

// File: rtl/dma_csr_cmd_dec.sv
module dma_csr_cmd_dec
  import dma_csr_pkg::*;
(
  input  logic                      we,
  input  logic                      sel_en,
  input  logic                      sel_ev,
  input  logic [NLANE-1:0]          be,
  input  logic [NLANE-1:0][CHW-1:0] lane_ch,
  output logic [NCH-1:0]            set_req,
  output logic [NCH-1:0]            clr_req,
  output logic [NCH-1:0]            set_eien,
  output logic [NCH-1:0]            clr_eien,
  output logic [NCH-1:0]            clr_int,
  output logic [NCH-1:0]            clr_err,
  output logic [NCH-1:0]            start_fire,
  output logic [NCH-1:0]            doneclr_fire
);
  logic [NLANE-1:0][NCH-1:0] en_vec;
  logic [NLANE-1:0][NCH-1:0] ev_vec;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    assign en_vec[l] = (we && sel_en && be[l]) ? chan_bit(lane_ch[l]) : '0;
    assign ev_vec[l] = (we && sel_ev && be[l]) ? chan_bit(lane_ch[l]) : '0;
  end

  assign set_req      = en_vec[0];
  assign clr_req      = en_vec[1];
  assign set_eien     = en_vec[2];
  assign clr_eien     = en_vec[3];
  assign clr_int      = ev_vec[0];
  assign clr_err      = ev_vec[1];
  assign start_fire   = ev_vec[2];
  assign doneclr_fire = ev_vec[3];
endmodule

// File: rtl/dma_csr_flagbank.sv
module dma_csr_flagbank
  import dma_csr_pkg::*;
#(
  parameter bit W1C = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_hi,
  input  logic           wr_lo,
  input  logic [DW-1:0]  wdata,
  input  logic [DW-1:0]  wmask,
  input  logic [NCH-1:0] set_vec,
  input  logic [NCH-1:0] clr_vec,
  input  logic [NCH-1:0] hw_set,
  output logic [NCH-1:0] q
);
  logic [DW-1:0]  hi_m, lo_m;
  logic [NCH-1:0] bus_view, nxt;

  if (W1C) begin : g_w1c
    assign hi_m = w1c_merge(q[NCH-1:DW], wdata, wmask);
    assign lo_m = w1c_merge(q[DW-1:0], wdata, wmask);
  end else begin : g_rw
    assign hi_m = rw_merge(q[NCH-1:DW], wdata, wmask);
    assign lo_m = rw_merge(q[DW-1:0], wdata, wmask);
  end

  always_comb begin
    bus_view = {wr_hi ? hi_m : q[NCH-1:DW], wr_lo ? lo_m : q[DW-1:0]};
    // Hardware set is applied last so it wins over any clear (R9).
    nxt = (bus_view & ~clr_vec) | set_vec | hw_set;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= nxt;
  end

  assert_hw_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((q & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/dma_csr_errcap.sv
module dma_csr_errcap
  import dma_csr_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSRC-1:0]        evt_err,
  input  logic [NSRC*CHW-1:0]    evt_chan,
  input  logic [NSRC*CAUSEW-1:0] evt_cause,
  input  logic                   clr,
  output logic [DW-1:0]          estat,
  output logic                   capture
);
  logic              any_err;
  logic [CHW-1:0]    best_ch;
  logic [CAUSEW-1:0] best_cause;

  always_comb begin
    any_err    = 1'b0;
    best_ch    = '1;
    best_cause = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (evt_err[s] && (!any_err || evt_chan[s*CHW +: CHW] < best_ch)) begin
        best_ch    = evt_chan[s*CHW +: CHW];
        best_cause = evt_cause[s*CAUSEW +: CAUSEW];
        any_err    = 1'b1;
      end
    end
  end

  assign capture = any_err && (!estat[31] || clr);

  always_ff @(posedge clk) begin
    if (!rst_n)       estat <= '0;
    else if (capture) estat <= estat_pack(best_ch, best_cause);
    else if (clr)     estat <= '0;
  end

  assert_estat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (estat[31] && !clr) |=> $stable(estat));
  assert_estat_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (any_err && !estat[31]) |=> estat[31]);
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int NSRC = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_we,
  input  logic [AW-1:0]          bus_addr,
  input  logic [NLANE-1:0]       bus_be,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [NSRC-1:0]        evt_done,
  input  logic [NSRC-1:0]        evt_err,
  input  logic [NSRC*CHW-1:0]    evt_chan,
  input  logic [NSRC*CAUSEW-1:0] evt_cause,
  output logic                   irq,
  output logic [NCH-1:0]         req_en,
  output logic [NCH-1:0]         err_int_en,
  output logic [NCH-1:0]         start_pulse,
  output logic [NCH-1:0]         done_clr,
  output logic                   clk_gate_en,
  output logic                   rr_group,
  output logic                   rr_chan
);
  logic [DW-1:0]  wmask;
  logic [DW-1:0]  ctrl_q, estat;
  logic [NCH-1:0] int_q, err_q;
  logic [NCH-1:0] set_req, clr_req, set_eien, clr_eien, clr_int, clr_err;
  logic [NCH-1:0] start_fire, doneclr_fire;
  logic [NCH-1:0] done_hits, err_hits;
  logic [NLANE-1:0][CHW-1:0] lane_ch;
  logic           estat_clr, estat_capture;

  assign wmask = lane_mask(bus_be);

  for (genvar l = 0; l < NLANE; l++) begin : g_lane_ch
    assign lane_ch[l] = bus_wdata[8*l +: CHW];
  end

  always_comb begin
    done_hits = '0;
    err_hits  = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (evt_done[s]) done_hits = done_hits | chan_bit(evt_chan[s*CHW +: CHW]);
      if (evt_err[s])  err_hits  = err_hits  | chan_bit(evt_chan[s*CHW +: CHW]);
    end
  end

  dma_csr_cmd_dec u_cmd (
    .we(bus_we), .sel_en(bus_addr == A_CMD_EN), .sel_ev(bus_addr == A_CMD_EV),
    .be(bus_be), .lane_ch(lane_ch),
    .set_req(set_req), .clr_req(clr_req), .set_eien(set_eien), .clr_eien(clr_eien),
    .clr_int(clr_int), .clr_err(clr_err),
    .start_fire(start_fire), .doneclr_fire(doneclr_fire)
  );

  dma_csr_flagbank #(.W1C(1'b0)) u_reqen (
    .clk(clk), .rst_n(rst_n),
    .wr_hi(bus_we && bus_addr == A_REQEN_H), .wr_lo(bus_we && bus_addr == A_REQEN_L),
    .wdata(bus_wdata), .wmask(wmask),
    .set_vec(set_req), .clr_vec(clr_req), .hw_set('0), .q(req_en)
  );

  dma_csr_flagbank #(.W1C(1'b0)) u_eien (
    .clk(clk), .rst_n(rst_n),
    .wr_hi(bus_we && bus_addr == A_EIEN_H), .wr_lo(bus_we && bus_addr == A_EIEN_L),
    .wdata(bus_wdata), .wmask(wmask),
    .set_vec(set_eien), .clr_vec(clr_eien), .hw_set('0), .q(err_int_en)
  );

  dma_csr_flagbank #(.W1C(1'b1)) u_int (
    .clk(clk), .rst_n(rst_n),
    .wr_hi(bus_we && bus_addr == A_INT_H), .wr_lo(bus_we && bus_addr == A_INT_L),
    .wdata(bus_wdata), .wmask(wmask),
    .set_vec('0), .clr_vec(clr_int), .hw_set(done_hits), .q(int_q)
  );

  dma_csr_flagbank #(.W1C(1'b1)) u_err (
    .clk(clk), .rst_n(rst_n),
    .wr_hi(bus_we && bus_addr == A_ERR_H), .wr_lo(bus_we && bus_addr == A_ERR_L),
    .wdata(bus_wdata), .wmask(wmask),
    .set_vec('0), .clr_vec(clr_err), .hw_set(err_hits), .q(err_q)
  );

  assign estat_clr = bus_we && bus_addr == A_ESTAT && bus_be[3] && bus_wdata[31];

  dma_csr_errcap #(.NSRC(NSRC)) u_errcap (
    .clk(clk), .rst_n(rst_n), .evt_err(evt_err), .evt_chan(evt_chan),
    .evt_cause(evt_cause), .clr(estat_clr), .estat(estat), .capture(estat_capture)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q      <= '0;
      start_pulse <= '0;
      done_clr    <= '0;
    end else begin
      if (bus_we && bus_addr == A_CTRL)
        ctrl_q <= rw_merge(ctrl_q, bus_wdata, wmask) & CTRL_MASK;
      start_pulse <= start_fire;
      done_clr    <= doneclr_fire;
    end
  end

  assign clk_gate_en = ctrl_q[31];
  assign rr_group    = ctrl_q[3];
  assign rr_chan     = ctrl_q[2];

  assign irq = (|int_q) || (|(err_q & err_int_en));

  always_comb begin
    case (bus_addr)
      A_CTRL:    bus_rdata = ctrl_q;
      A_ESTAT:   bus_rdata = estat;
      A_REQEN_H: bus_rdata = req_en[NCH-1:DW];
      A_REQEN_L: bus_rdata = req_en[DW-1:0];
      A_EIEN_H:  bus_rdata = err_int_en[NCH-1:DW];
      A_EIEN_L:  bus_rdata = err_int_en[DW-1:0];
      A_INT_H:   bus_rdata = int_q[NCH-1:DW];
      A_INT_L:   bus_rdata = int_q[DW-1:0];
      A_ERR_H:   bus_rdata = err_q[NCH-1:DW];
      A_ERR_L:   bus_rdata = err_q[DW-1:0];
      default:   bus_rdata = '0;
    endcase
  end

  assert_start_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_pulse) && $onehot0(done_clr));
  assert_irq_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|evt_done) || (|evt_err) || bus_we));
  assert_capture_needs_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    estat_capture |-> (|evt_err));
endmodule

// File: tb/dma_csr_bank_bench.sv
module dma_csr_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  evt_done = '0;
  logic [1:0]  evt_err = '0;
  logic [11:0] evt_chan = '0;
  logic [31:0] evt_cause = '0;
  logic        irq, clk_gate_en, rr_group, rr_chan;
  logic [63:0] req_en, err_int_en, start_pulse, done_clr;

  int n_checks = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dma_csr_bank u_dma_csr_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_done(evt_done), .evt_err(evt_err),
    .evt_chan(evt_chan), .evt_cause(evt_cause), .irq(irq), .req_en(req_en),
    .err_int_en(err_int_en), .start_pulse(start_pulse), .done_clr(done_clr),
    .clk_gate_en(clk_gate_en), .rr_group(rr_group), .rr_chan(rr_chan)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    step();
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic rchk(input string tag, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(tag, {32'd0, d}, {32'd0, exp});
  endtask

  task automatic ev(input logic [1:0] dn, input logic [1:0] er, input logic [5:0] c0,
                    input logic [5:0] c1, input logic [15:0] k0, input logic [15:0] k1);
    evt_done = dn; evt_err = er; evt_chan = {c1, c0}; evt_cause = {k1, k0};
    step();
    evt_done = '0; evt_err = '0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 12; a++) rchk("R1 word zero", 6'(a), 32'h0);
    chk("R1 irq", {63'd0, irq}, 64'd0);
    chk("R1 strobes", start_pulse | done_clr, 64'd0);
  endtask

  task automatic t_ctrl();
    wr(6'd0, 32'hFFFF_FFFF, 4'hF);
    rchk("R2 ctrl mask", 6'd0, 32'h8000_000C);
    chk("R2 ctrl outs", {61'd0, clk_gate_en, rr_group, rr_chan}, 64'd7);
    wr(6'd0, 32'h0000_0004, 4'h1);
    rchk("R2 ctrl lane", 6'd0, 32'h8000_0004);
  endtask

  task automatic t_direct();
    wr(6'd3, 32'hA5A5_1234, 4'b0011);
    rchk("R3 reqen lo bytes", 6'd3, 32'h0000_1234);
    wr(6'd2, 32'hFFFF_FFFF, 4'hF);
    chk("R3 reqen hi map", req_en, 64'hFFFF_FFFF_0000_1234);
    wr(6'd5, 32'h0000_0100, 4'hF);
    chk("R3 eien lo map", err_int_en, 64'h100);
    wr(6'd2, 32'h0, 4'hF); wr(6'd3, 32'h0, 4'hF); wr(6'd5, 32'h0, 4'hF);
  endtask

  task automatic t_cmd_en();
    wr(6'd6, 32'h0000_00C5, 4'b0001);
    chk("R4 set req upper bits ignored", req_en, 64'd1 << 5);
    wr(6'd6, 32'h0000_0028, 4'b0001);
    rchk("R4 set req hi word", 6'd2, 32'h0000_0100);
    wr(6'd6, 32'h0000_0500, 4'b0010);
    chk("R4 clr req", req_en, 64'd1 << 40);
    wr(6'd6, 32'h0000_0007, 4'b0010);
    chk("R4 disabled lane", req_en, 64'd1 << 40);
    wr(6'd6, 32'h003F_0000, 4'b0100);
    rchk("R4 set eien", 6'd4, 32'h8000_0000);
    wr(6'd6, 32'h3F00_0000, 4'b1000);
    chk("R4 clr eien", err_int_en, 64'd0);
    wr(6'd2, 32'h0, 4'hF);
  endtask

  task automatic t_strobes();
    wr(6'd7, 32'h0011_0000, 4'b0100);
    chk("R5 start pulse", start_pulse, 64'd1 << 17);
    step();
    chk("R5 start one cycle", start_pulse, 64'd0);
    wr(6'd7, 32'h3200_0000, 4'b1000);
    chk("R5 done clr pulse", done_clr, 64'd1 << 50);
    step();
    chk("R5 done clr one cycle", done_clr, 64'd0);
  endtask

  task automatic t_done_evt();
    ev(2'b11, 2'b00, 6'd3, 6'd35, 16'h0, 16'h0);
    rchk("R6 int lo", 6'd9, 32'h8);
    rchk("R6 int hi", 6'd8, 32'h8);
    chk("R12 irq on done", {63'd0, irq}, 64'd1);
    wr(6'd9, 32'h0000_0008, 4'b0001);
    rchk("R6 w1c lo", 6'd9, 32'h0);
    chk("R12 irq still hi", {63'd0, irq}, 64'd1);
    wr(6'd8, 32'hFFFF_FFFF, 4'hF);
    rchk("R6 all ones clear", 6'd8, 32'h0);
    chk("R12 irq low", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_err_evt();
    ev(2'b00, 2'b01, 6'd9, 6'd0, 16'h0001, 16'h0);
    rchk("R7 err flag", 6'd11, 32'h200);
    chk("R7 masked irq", {63'd0, irq}, 64'd0);
    wr(6'd6, 32'h0009_0000, 4'b0100);
    chk("R7 enabled irq", {63'd0, irq}, 64'd1);
    wr(6'd11, 32'hFFFF_FFFF, 4'hF);
    chk("R7 irq after w1c", {63'd0, irq}, 64'd0);
    wr(6'd5, 32'h0, 4'hF);
    wr(6'd1, 32'h8000_0000, 4'b1000);
  endtask

  task automatic t_cmd_clr();
    ev(2'b11, 2'b00, 6'd60, 6'd2, 16'h0, 16'h0);
    wr(6'd7, 32'h0000_003C, 4'b0001);
    rchk("R8 clr int hi", 6'd8, 32'h0);
    rchk("R8 other kept", 6'd9, 32'h4);
    ev(2'b00, 2'b01, 6'd33, 6'd0, 16'h0, 16'h0);
    wr(6'd7, 32'h0000_2100, 4'b0010);
    rchk("R8 clr err", 6'd10, 32'h0);
    wr(6'd9, 32'hFFFF_FFFF, 4'hF);
    wr(6'd1, 32'h8000_0000, 4'b1000);
  endtask

  task automatic t_hw_wins();
    evt_done = 2'b01; evt_chan = {6'd0, 6'd4};
    wr(6'd9, 32'h0000_0010, 4'b0001);
    evt_done = '0;
    rchk("R9 event beats w1c", 6'd9, 32'h10);
    evt_done = 2'b01;
    wr(6'd7, 32'h0000_0004, 4'b0001);
    evt_done = '0;
    rchk("R9 event beats cmd", 6'd9, 32'h10);
    wr(6'd9, 32'h0000_0010, 4'b0001);
    rchk("R9 clear alone", 6'd9, 32'h0);
  endtask

  task automatic t_estat();
    ev(2'b00, 2'b01, 6'd22, 6'd0, 16'hFFFF, 16'h0);
    rchk("R10 capture", 6'd1, 32'h8000_D6FF);
    ev(2'b00, 2'b01, 6'd1, 6'd0, 16'h0002, 16'h0);
    rchk("R10 hold", 6'd1, 32'h8000_D6FF);
    wr(6'd1, 32'h8000_0000, 4'b0111);
    rchk("R10 lane3 off", 6'd1, 32'h8000_D6FF);
    wr(6'd1, 32'h8000_0000, 4'b1000);
    rchk("R10 clear", 6'd1, 32'h0);
    wr(6'd11, 32'hFFFF_FFFF, 4'hF);
  endtask

  task automatic t_lowest();
    ev(2'b00, 2'b11, 6'd45, 6'd12, 16'h0010, 16'h4000);
    rchk("R11 lowest chan", 6'd1, 32'h8000_4C00);
    rchk("R11 both flags lo", 6'd11, 32'h0000_1000);
    rchk("R11 both flags hi", 6'd10, 32'h0000_2000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_direct();
    t_cmd_en();
    t_strobes();
    t_done_evt();
    t_err_evt();
    t_cmd_clr();
    t_hw_wins();
    t_estat();
    t_lowest();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule